// File: doc/BRIEF.md
# Strobed Serial Configuration Register

This block takes a 20-bit control word for a motor bridge driver over a three-wire port (serial clock, serial data, strobe) and keeps it in a holding register. The strobe rests high. A write pulls it low, shifts the word in most-significant bit first on rising serial-clock edges, and raises it again. The word is copied to the holding register on that rising strobe edge, but only if exactly twenty clock edges arrived while the strobe was low. Every other frame length is thrown away.

The held word is presented as decoded fields: blanking select, off-time count, fast-decay count, rectification mode and enable, external decay mode, test and sleep. Four bits of the word do not act directly. Each one sets the polarity of an external pin, and the block compares the pin with its bit to produce the chop, direction, reference-divider and decay-mix controls. An undervoltage input clears the held word, and all serial state, to zero at once.

The serial inputs are sampled by the block's own core clock through a synchronizer. For this reason each serial-clock level must last for at least three core-clock cycles.

Top module: `strobed_cfg_reg`

## Requirements
- R1: While `uvlo` is high, the held word is all zeros. With a zero word, `chop` = 1 when `enable_pin` is 0, `forward` = `phase_pin`, `div10` = 1 when `range_pin` is 0, and `mixed_decay` = `mode_pin`.
- R2: After a valid frame, the first bit shifted in lands at word bit 19. The word bits are decoded as follows: `blank_sel` = bits 1:0, `off_count` = bits 6:2, `fast_count` = bits 10:7, `rect_active` = bit 11, `rect_on` = bit 12, `ext_slow` = bit 13, `test_bit` = bit 18, `sleep_req` = bit 19.
- R3: A frame with exactly 20 rising serial-clock edges during the strobe-low period replaces the held word when the strobe rises.
- R4: A frame with fewer than 20 edges, including none at all, leaves every output unchanged.
- R5: A frame with more than 20 edges leaves every output unchanged.
- R6: Serial-clock edges while the strobe is high do not change the outputs.
- R7: `chop` is 1 when `enable_pin` equals word bit 14, and 0 otherwise.
- R8: `forward` is 1 when `phase_pin` differs from word bit 15, and 0 otherwise.
- R9: `div10` is 1 when `range_pin` equals word bit 16, and 0 otherwise (0 selects divide by 5).
- R10: `mixed_decay` is 1 when `mode_pin` differs from word bit 17, and 0 otherwise (0 selects slow decay).
- R11: While a frame is being shifted in, the outputs keep the previously held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial inputs |
| uvlo | input | 1 | Undervoltage lockout, active high, clears all state |
| ser_clk | input | 1 | Serial clock, shifts on its rising edge |
| ser_data | input | 1 | Serial data, most-significant bit first |
| ser_strobe | input | 1 | Frame strobe, idle high, low during a write |
| range_pin | input | 1 | Reference range pin |
| mode_pin | input | 1 | Decay mode pin |
| phase_pin | input | 1 | Direction pin |
| enable_pin | input | 1 | Bridge enable pin |
| blank_sel | output | 2 | Blanking time select |
| off_count | output | 5 | Fixed off-time count |
| fast_count | output | 4 | Fast-decay portion count |
| rect_active | output | 1 | Rectification mode (1 = active) |
| rect_on | output | 1 | Synchronous rectification enable |
| ext_slow | output | 1 | Decay mode under external chopping |
| test_bit | output | 1 | Test mode bit |
| sleep_req | output | 1 | Sleep request bit |
| chop | output | 1 | Bridge chopped (1) or driving (0) |
| forward | output | 1 | Direction forward (1) or reverse (0) |
| div10 | output | 1 | Reference divided by 10 (1) or by 5 (0) |
| mixed_decay | output | 1 | Mixed decay (1) or slow decay (0) |

## Verification
The frames sent use three words with different bit patterns, all ones and all zeros. Each field slice is therefore checked against neighbours that hold different values, and a shift in either direction would show. Frame lengths of 0, 19, 20 and 21 edges test whether the edge count gates the commit, both below and above the exact value. Clock pulses with the strobe high test whether shifting is qualified by the strobe. All sixteen pin combinations are applied twice, once with the four polarity bits set and once with them clear. This shows that each pin-derived output follows its own pin and its own bit, with the correct sense.

// File: rtl/strobed_cfg_pkg.sv
package strobed_cfg_pkg;

  // Field record; member order follows the bit position the serial stream assigns.
  typedef struct packed {
    logic       sleep;
    logic       test;
    logic       mode_pol;
    logic       range_pol;
    logic       phase_pol;
    logic       en_pol;
    logic       ext_decay;
    logic       rect_en;
    logic       rect_mode;
    logic [3:0] fast;
    logic [4:0] off;
    logic [1:0] blank;
  } cfg_word_t;

  localparam int WORD_W = $bits(cfg_word_t);
  localparam int CNT_W  = $clog2(WORD_W + 2);

  // 1 when an external pin agrees with its polarity bit.
  function automatic logic pol_match(input logic pin, input logic pol);
    return ~(pin ^ pol);
  endfunction

  // Saturating increment for the frame edge counter.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] cnt,
                                              input logic [CNT_W-1:0] limit);
    return (cnt >= limit) ? limit : cnt + 1'b1;
  endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int              WIDTH     = 3,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] r;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) r <= RESET_VAL;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      localparam int CW = STAGES * WIDTH;
      logic [CW-1:0] chain;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[CW-WIDTH-1:0], d};
      end
      assign q = chain[CW-1 -: WIDTH];
    end
  endgenerate

endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter
  import strobed_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              stb_s,
  output logic [WORD_W-1:0] shift_word,
  output logic [CNT_W-1:0]  edge_cnt,
  output logic              stb_rise,
  output logic              word_load,
  output logic              word_drop
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic sclk_q, stb_q;
  logic sclk_rise, stb_fall, shift_en;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign stb_fall  = ~stb_s & stb_q;
  assign stb_rise  = stb_s & ~stb_q;
  assign shift_en  = sclk_rise & ~stb_s;

  assign word_load = stb_rise & (edge_cnt == CNT_FULL);
  assign word_drop = stb_rise & (edge_cnt != CNT_FULL);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclk_q <= 1'b0;
      stb_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      stb_q  <= stb_s;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           shift_word <= '0;
    else if (shift_en) shift_word <= {shift_word[WORD_W-2:0], sdat_s};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           edge_cnt <= '0;
    else if (stb_fall) edge_cnt <= shift_en ? CNT_W'(1) : '0;
    else if (shift_en) edge_cnt <= sat_inc(edge_cnt, CNT_SAT);
  end

endmodule

// File: rtl/scfg_holder.sv
module scfg_holder
  import strobed_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output cfg_word_t         held
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       held <= '0;
    else if (load) held <= cfg_word_t'(word_in);
  end

endmodule

// File: rtl/strobed_cfg_reg.sv
module strobed_cfg_reg
  import strobed_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       uvlo,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic       ser_strobe,
  input  logic       range_pin,
  input  logic       mode_pin,
  input  logic       phase_pin,
  input  logic       enable_pin,
  output logic [1:0] blank_sel,
  output logic [4:0] off_count,
  output logic [3:0] fast_count,
  output logic       rect_active,
  output logic       rect_on,
  output logic       ext_slow,
  output logic       test_bit,
  output logic       sleep_req,
  output logic       chop,
  output logic       forward,
  output logic       div10,
  output logic       mixed_decay
);

  logic [2:0]        ser_s;
  logic              stb_s, sclk_s, sdat_s;
  logic [WORD_W-1:0] shift_word;
  logic [CNT_W-1:0]  edge_cnt;
  logic              stb_rise, word_load, word_drop;
  cfg_word_t         held_word;

  scfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (uvlo),
    .d   ({ser_strobe, ser_clk, ser_data}),
    .q   (ser_s)
  );

  assign {stb_s, sclk_s, sdat_s} = ser_s;

  scfg_shifter u_shift (
    .clk        (clk),
    .rst        (uvlo),
    .sclk_s     (sclk_s),
    .sdat_s     (sdat_s),
    .stb_s      (stb_s),
    .shift_word (shift_word),
    .edge_cnt   (edge_cnt),
    .stb_rise   (stb_rise),
    .word_load  (word_load),
    .word_drop  (word_drop)
  );

  scfg_holder u_hold (
    .clk     (clk),
    .rst     (uvlo),
    .load    (word_load),
    .word_in (shift_word),
    .held    (held_word)
  );

  assign blank_sel   = held_word.blank;
  assign off_count   = held_word.off;
  assign fast_count  = held_word.fast;
  assign rect_active = held_word.rect_mode;
  assign rect_on     = held_word.rect_en;
  assign ext_slow    = held_word.ext_decay;
  assign test_bit    = held_word.test;
  assign sleep_req   = held_word.sleep;

  assign chop        =  pol_match(enable_pin, held_word.en_pol);
  assign forward     = ~pol_match(phase_pin,  held_word.phase_pol);
  assign div10       =  pol_match(range_pin,  held_word.range_pol);
  assign mixed_decay = ~pol_match(mode_pin,   held_word.mode_pol);

endmodule

// File: rtl/strobed_cfg_reg_chk.sv
module strobed_cfg_reg_chk
  import strobed_cfg_pkg::*;
(
  input logic              clk,
  input logic              uvlo,
  input logic              stb_s,
  input logic              word_load,
  input logic              word_drop,
  input logic [CNT_W-1:0]  edge_cnt,
  input logic [WORD_W-1:0] shift_word,
  input logic [WORD_W-1:0] held_word
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (uvlo)
    word_load |=> held_word == $past(shift_word));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (uvlo)
    !word_load |=> $stable(held_word));

  assert_bad_frame_kept_R4: assert property (@(posedge clk) disable iff (uvlo)
    word_drop |=> $stable(held_word));

  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (uvlo)
    edge_cnt <= CNT_SAT);

  assert_no_shift_idle_R6: assert property (@(posedge clk) disable iff (uvlo)
    stb_s |=> $stable(shift_word));

endmodule

bind strobed_cfg_reg strobed_cfg_reg_chk u_chk (
  .clk        (clk),
  .uvlo       (uvlo),
  .stb_s      (stb_s),
  .word_load  (word_load),
  .word_drop  (word_drop),
  .edge_cnt   (edge_cnt),
  .shift_word (shift_word),
  .held_word  (held_word)
);

// File: tb/tb_strobed_cfg_reg.sv
module tb_strobed_cfg_reg;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic uvlo, sck, sdi, stb, rng, mde, phs, ena;
  logic [1:0] blank_sel;
  logic [4:0] off_count;
  logic [3:0] fast_count;
  logic rect_active, rect_on, ext_slow, test_bit, sleep_req;
  logic chop, forward, div10, mixed_decay;

  strobed_cfg_reg dut (
    .clk(clk), .uvlo(uvlo), .ser_clk(sck), .ser_data(sdi), .ser_strobe(stb),
    .range_pin(rng), .mode_pin(mde), .phase_pin(phs), .enable_pin(ena),
    .blank_sel(blank_sel), .off_count(off_count), .fast_count(fast_count),
    .rect_active(rect_active), .rect_on(rect_on), .ext_slow(ext_slow),
    .test_bit(test_bit), .sleep_req(sleep_req), .chop(chop), .forward(forward),
    .div10(div10), .mixed_decay(mixed_decay)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [19:0] w;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [19:0] model;
  event        frame_done;

  task automatic compare_out(input logic [19:0] w, input string tag);
    logic [21:0] act, exp;
    act = {blank_sel, off_count, fast_count, rect_active, rect_on, ext_slow,
           test_bit, sleep_req, chop, forward, div10, mixed_decay};
    exp = {w[1:0], w[6:2], w[10:7], w[11], w[12], w[13], w[18], w[19],
           (ena == w[14]), (phs != w[15]), (rng == w[16]), (mde != w[17])};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs act=%h exp=%h (pins r%0b m%0b p%0b e%0b)",
               tag, act, exp, rng, mde, phs, ena);
    end
  endtask

  task automatic half_bit();
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [19:0] w, input int n, input string tag);
    stb = 1'b0;
    half_bit();
    for (int i = 0; i < n; i++) begin
      sdi = (i < 20) ? w[19-i] : 1'b1;
      if (n == 20 && i == 10) compare_out(model, "R11 mid-frame");
      half_bit();
      sck = 1'b1;
      half_bit();
      sck = 1'b0;
    end
    half_bit();
    stb = 1'b1;
    if (n == 20) model = w;
    sb.push_back('{model, tag});
    -> frame_done;
    repeat (14) @(negedge clk);
  endtask

  task automatic idle_clocks(input string tag);
    sdi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      half_bit();
      sck = 1'b1;
      half_bit();
      sck = 1'b0;
    end
    sb.push_back('{model, tag});
    -> frame_done;
    repeat (14) @(negedge clk);
  endtask

  task automatic pin_sweep(input string tag);
    for (int p = 0; p < 16; p++) begin
      {rng, mde, phs, ena} = 4'(p);
      @(negedge clk);
      compare_out(model, tag);
    end
    {rng, mde, phs, ena} = 4'b0;
    @(negedge clk);
  endtask

  // Monitor: pops the expected word once the commit has had time to land.
  initial begin
    exp_t item;
    forever begin
      @(frame_done);
      repeat (8) @(negedge clk);
      if (sb.size() != 0) begin
        item = sb.pop_front();
        compare_out(item.w, item.tag);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    uvlo = 1'b1;
    sck = 1'b0; sdi = 1'b0; stb = 1'b1;
    rng = 1'b0; mde = 1'b0; phs = 1'b0; ena = 1'b0;
    model = '0;
    repeat (5) @(negedge clk);
    compare_out(20'h0, "R1 reset");
    uvlo = 1'b0;
    repeat (5) @(negedge clk);

    send(20'hA5C3B, 20, "R2 R3 pattern A");
    send(20'h12345, 19, "R4 short frame");
    send(20'h00000, 0,  "R4 empty frame");
    send(20'h0F0F0, 21, "R5 long frame");
    idle_clocks("R6 clocks with strobe high");
    send(20'h5A6C9, 20, "R3 pattern B");

    send(20'h3C000, 20, "R2 polarity bits set");
    pin_sweep("R7 R8 R9 R10 bits set");
    send(20'h00123, 20, "R2 polarity bits clear");
    pin_sweep("R7 R8 R9 R10 bits clear");

    send(20'hFFFFF, 20, "R2 all ones");
    uvlo = 1'b1;
    repeat (2) @(negedge clk);
    model = '0;
    compare_out(model, "R1 undervoltage clear");
    {rng, mde, phs, ena} = 4'b1010;
    @(negedge clk);
    compare_out(model, "R1 cleared word with pins");
    {rng, mde, phs, ena} = 4'b0;
    uvlo = 1'b0;
    repeat (5) @(negedge clk);
    send(20'h8F0F1, 20, "R2 after undervoltage");

    repeat (10) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule